// File: doc/BRIEF.md
# Instruction Fetch Mode Controller

This controller decides, one fetch at a time, where the instruction fetch unit reads from. There are three choices. The first is the small level-0 store. The second is the level-1 cache. The third is a promoting mode, which reads from level 1 and writes the fetched line into level 0.

The decision is driven by the branch-table lookup that goes with each fetch. That lookup supplies:

- whether the table hit;
- whether the entry is a predicted-taken branch;
- the entry's hot flag and previous-hot flag;
- whether its execution counter has reached the candidate threshold;
- the entry index.

Two more inputs take part: a level-0 miss indicator and a flag that marks the profiling stage. Only taken-branch hits and level-0 misses change the mode. Every other fetch keeps the mode chosen at the last taken branch, so a whole basic block is fetched from one source.

When a promoting run ends, the controller sends a one-cycle pulse back to the branch table. The pulse carries the index of the branch that started the run, so the table can set that entry's hot flag. The mode output is registered. A decision made from the inputs of one cycle appears on the outputs after the next rising clock edge.

Top module: `fetch_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the mode is level-1 (code 0) and no promote-done pulse is driven.
- R2: A table hit on a taken entry with either the hot flag or the previous-hot flag set makes the next mode level-0 (code 1).
- R3: A table hit on a taken entry with both flags clear and the counter below threshold makes the next mode level-1.
- R4: A table hit on a taken entry with both flags clear and the counter at threshold, during the profiling stage, makes the next mode promoting (code 2).
- R5: The condition in R4 outside the profiling stage makes the next mode level-1 instead.
- R6: A level-0 miss makes the next mode level-1, whatever the lookup shows in the same cycle.
- R7: A table miss, or a hit on a not-taken entry (valid = 0), leaves the mode unchanged.
- R8: When the mode leaves promoting, a one-cycle promote-done pulse is driven. It appears in the same cycle as the new mode and carries the index of the branch that started the run.
- R9: A new promoting hit while already promoting ends the current run with a done pulse for the old index, and starts a new run on the new index.
- R10: The level-0 read select is high only in level-0 mode, and the level-0 fill strobe is high only in promoting mode. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_hit | input | 1 | Branch table hit for this fetch |
| lk_taken | input | 1 | Entry valid bit: predicted taken |
| lk_hot | input | 1 | Entry hot flag |
| lk_prev_hot | input | 1 | Entry previous-hot flag |
| lk_at_thr | input | 1 | Entry execution counter equals the candidate threshold |
| lk_idx | input | IDX_W | Index of the table entry that hit |
| l0_miss | input | 1 | Level-0 store missed this fetch |
| profiling | input | 1 | System is in the profiling stage |
| mode_o | output | 2 | Current fetch mode: 0 level-1, 1 level-0, 2 promoting |
| l0_sel_o | output | 1 | Read from level-0 |
| l0_fill_o | output | 1 | Copy the fetched line into level-0 |
| promo_done_o | output | 1 | One-cycle pulse: the promoting run has finished |
| promo_idx_o | output | IDX_W | Entry index to mark hot; valid with promo_done_o |

## Verification
The rules are tried with several kinds of stimulus:

- Directed lookups, one per transition rule. These separate the hot and previous-hot cases from the below-threshold and at-threshold cases.
- The at-threshold case inside and outside profiling. This tells promoting apart from its downgrade to level-1.
- Lookups that coincide with a level-0 miss. These show whether the miss wins.
- Streams of table misses and not-taken hits after each mode. These show that the mode is held rather than reset.
- Back-to-back promoting hits. These expose whether the done pulse carries the old or the new index.
- Long random mixes. These cover the transitions between all pairs of modes.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  typedef enum logic [1:0] {
    FM_L1    = 2'd0,
    FM_L0    = 2'd1,
    FM_PROMO = 2'd2
  } fmode_e;

  typedef struct packed {
    logic hit;
    logic taken;
    logic hot;
    logic prev_hot;
    logic at_thr;
  } lookup_t;

endpackage

// File: rtl/fmc_rst_sync.sv
module fmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fmc_event_decode.sv
module fmc_event_decode
  import fmc_pkg::*;
(
  input  lookup_t lk,
  input  logic    l0_miss,
  input  logic    profiling,
  output logic    change,
  output fmode_e  target,
  output logic    promo_trig
);
  logic taken_hit;
  logic any_hot;
  logic at_cand;

  assign taken_hit = lk.hit & lk.taken;
  assign any_hot   = lk.hot | lk.prev_hot;
  assign at_cand   = taken_hit & ~any_hot & lk.at_thr;

  always_comb begin
    change     = 1'b0;
    target     = FM_L1;
    promo_trig = 1'b0;
    if (l0_miss) begin
      change = 1'b1;
      target = FM_L1;
    end else if (taken_hit) begin
      change = 1'b1;
      if (any_hot) begin
        target = FM_L0;
      end else if (at_cand && profiling) begin
        target     = FM_PROMO;
        promo_trig = 1'b1;
      end else begin
        target = FM_L1;
      end
    end
  end
endmodule

// File: rtl/fmc_mode_reg.sv
module fmc_mode_reg
  import fmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   change,
  input  fmode_e target,
  output fmode_e mode_q,
  output fmode_e mode_d
);
  logic mode_en;

  assign mode_en = change;

  always_comb begin
    mode_d = mode_q;
    if (mode_en) mode_d = target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= FM_L1;
    else if (mode_en) mode_q <= mode_d;
  end
endmodule

// File: rtl/fmc_promo_track.sv
module fmc_promo_track
  import fmc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fmode_e           mode_q,
  input  fmode_e           mode_d,
  input  logic             promo_trig,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             done_o,
  output logic [IDX_W-1:0] done_idx_o
);
  logic             leave;
  logic             cur_en;
  logic [IDX_W-1:0] cur_idx_q;
  logic             done_q;
  logic [IDX_W-1:0] done_idx_q;

  assign leave  = (mode_q == FM_PROMO) & ((mode_d != FM_PROMO) | promo_trig);
  assign cur_en = promo_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_idx_q <= '0;
    else if (cur_en) cur_idx_q <= lk_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= leave;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     done_idx_q <= '0;
    else if (leave) done_idx_q <= cur_idx_q;
  end

  assign done_o     = done_q;
  assign done_idx_o = done_idx_q;
endmodule

// File: rtl/fetch_mode_ctrl.sv
module fetch_mode_ctrl
  import fmc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_hit,
  input  logic             lk_taken,
  input  logic             lk_hot,
  input  logic             lk_prev_hot,
  input  logic             lk_at_thr,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic             l0_miss,
  input  logic             profiling,
  output logic [1:0]       mode_o,
  output logic             l0_sel_o,
  output logic             l0_fill_o,
  output logic             promo_done_o,
  output logic [IDX_W-1:0] promo_idx_o
);
  logic    rst_sync_n;
  lookup_t lk;
  logic    change;
  fmode_e  target;
  logic    promo_trig;
  fmode_e  mode_q;
  fmode_e  mode_d;

  assign lk = '{hit: lk_hit, taken: lk_taken, hot: lk_hot,
                prev_hot: lk_prev_hot, at_thr: lk_at_thr};

  fmc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fmc_event_decode u_dec (
    .lk         (lk),
    .l0_miss    (l0_miss),
    .profiling  (profiling),
    .change     (change),
    .target     (target),
    .promo_trig (promo_trig)
  );

  fmc_mode_reg u_mode (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .change (change),
    .target (target),
    .mode_q (mode_q),
    .mode_d (mode_d)
  );

  fmc_promo_track #(.IDX_W(IDX_W)) u_promo (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .promo_trig (promo_trig),
    .lk_idx     (lk_idx),
    .done_o     (promo_done_o),
    .done_idx_o (promo_idx_o)
  );

  assign mode_o    = mode_q;
  assign l0_sel_o  = (mode_q == FM_L0);
  assign l0_fill_o = (mode_q == FM_PROMO);
endmodule

// File: rtl/fetch_mode_ctrl_chk.sv
module fetch_mode_ctrl_chk #(
  parameter int IDX_W = 6
) (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       lk_hit,
  input logic       lk_taken,
  input logic       lk_hot,
  input logic       lk_prev_hot,
  input logic       lk_at_thr,
  input logic       l0_miss,
  input logic       profiling,
  input logic [1:0] mode_o,
  input logic       l0_sel_o,
  input logic       l0_fill_o,
  input logic       promo_done_o
);
  logic th;
  assign th = lk_hit & lk_taken;

  AST_MISS_FORCES_L1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    l0_miss |=> mode_o == 2'd0); // R6
  AST_HOT_GOES_L0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!l0_miss && th && (lk_hot || lk_prev_hot)) |=> mode_o == 2'd1); // R2
  AST_COLD_GOES_L1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!l0_miss && th && !lk_hot && !lk_prev_hot && !lk_at_thr) |=> mode_o == 2'd0); // R3
  AST_NO_PROMO_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!l0_miss && th && !lk_hot && !lk_prev_hot && lk_at_thr && !profiling) |=> mode_o == 2'd0); // R5
  AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!l0_miss && !th) |=> $stable(mode_o)); // R7
  AST_DONE_FROM_PROMO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    promo_done_o |-> $past(mode_o) == 2'd2); // R8
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({l0_sel_o, l0_fill_o})); // R10
endmodule

bind fetch_mode_ctrl fetch_mode_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .lk_hit       (lk_hit),
  .lk_taken     (lk_taken),
  .lk_hot       (lk_hot),
  .lk_prev_hot  (lk_prev_hot),
  .lk_at_thr    (lk_at_thr),
  .l0_miss      (l0_miss),
  .profiling    (profiling),
  .mode_o       (mode_o),
  .l0_sel_o     (l0_sel_o),
  .l0_fill_o    (l0_fill_o),
  .promo_done_o (promo_done_o)
);

// File: tb/fetch_mode_ctrl_tb.sv
module fetch_mode_ctrl_tb;
  localparam int IDX_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_hit, lk_taken, lk_hot, lk_prev_hot, lk_at_thr, l0_miss, profiling;
  logic [IDX_W-1:0] lk_idx;
  logic [1:0] mode_o;
  logic l0_sel_o, l0_fill_o, promo_done_o;
  logic [IDX_W-1:0] promo_idx_o;

  int checks = 0;
  int errors = 0;
  bit model_on = 0;
  bit finished = 0;

  int exp_mode = 0;
  bit exp_done = 0;
  int exp_didx = 0;
  int cur_idx = 0;
  string mode_req = "R1";
  string done_req = "R8";

  always #5 clk = ~clk;

  fetch_mode_ctrl #(.IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_hit(lk_hit), .lk_taken(lk_taken),
    .lk_hot(lk_hot), .lk_prev_hot(lk_prev_hot), .lk_at_thr(lk_at_thr),
    .lk_idx(lk_idx), .l0_miss(l0_miss), .profiling(profiling),
    .mode_o(mode_o), .l0_sel_o(l0_sel_o), .l0_fill_o(l0_fill_o),
    .promo_done_o(promo_done_o), .promo_idx_o(promo_idx_o)
  );

  // Behavioural reference, advanced on every rising edge.
  always @(posedge clk) begin
    if (model_on) begin
      int nm;
      bit trig;
      bit leave;
      trig = 0;
      if (l0_miss) begin
        nm = 0; mode_req = "R6";
      end else if (lk_hit && lk_taken) begin
        if (lk_hot || lk_prev_hot) begin
          nm = 1; mode_req = "R2";
        end else if (!lk_at_thr) begin
          nm = 0; mode_req = "R3";
        end else if (profiling) begin
          nm = 2; trig = 1; mode_req = "R4";
        end else begin
          nm = 0; mode_req = "R5";
        end
      end else begin
        nm = exp_mode; mode_req = "R7";
      end
      leave = (exp_mode == 2) && (nm != 2 || trig);
      exp_done = leave;
      done_req = (leave && trig) ? "R9" : "R8";
      if (leave) exp_didx = cur_idx;
      if (trig) cur_idx = int'(lk_idx);
      exp_mode = nm;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(int'(mode_o) == exp_mode, mode_req, "mode", int'(mode_o), exp_mode);
    check(l0_sel_o == (exp_mode == 1) && l0_fill_o == (exp_mode == 2), "R10",
          "select/fill", int'({l0_sel_o, l0_fill_o}), int'({exp_mode == 1, exp_mode == 2}));
    check(promo_done_o == exp_done, done_req, "done pulse", int'(promo_done_o), int'(exp_done));
    if (exp_done)
      check(int'(promo_idx_o) == exp_didx, done_req, "done index", int'(promo_idx_o), exp_didx);
  endtask

  task automatic drive(input bit hit, input bit tk, input bit hot, input bit ph,
                       input bit thr, input int idx, input bit miss, input bit prof);
    @(negedge clk);
    if (model_on) compare();
    lk_hit = hit; lk_taken = tk; lk_hot = hot; lk_prev_hot = ph;
    lk_at_thr = thr; lk_idx = IDX_W'(idx); l0_miss = miss; profiling = prof;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 0;
    lk_hit = 0; lk_taken = 0; lk_hot = 0; lk_prev_hot = 0;
    lk_at_thr = 0; lk_idx = '0; l0_miss = 0; profiling = 1;
    repeat (3) @(negedge clk);
    // R1: reset state while asserted
    check(mode_o == 2'd0 && !promo_done_o && !l0_sel_o && !l0_fill_o, "R1",
          "reset state", int'(mode_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(mode_o == 2'd0 && !promo_done_o, "R1", "after release", int'(mode_o), 0);
    model_on = 1;
    // Directed: R3 cold, R2 hot, R7 hold, prev-hot R2
    drive(1, 1, 0, 0, 0, 3, 0, 1); idle(2);
    drive(1, 1, 1, 0, 0, 4, 0, 1); idle(3);
    drive(1, 0, 0, 0, 1, 5, 0, 1); drive(0, 1, 1, 1, 1, 6, 0, 1);
    drive(1, 1, 0, 1, 0, 7, 0, 1); idle(1);
    // R6 miss overrides a hot lookup
    drive(1, 1, 1, 0, 0, 8, 1, 1); idle(2);
    // R4 promoting then leave via cold hit (R8)
    drive(1, 1, 0, 0, 1, 9, 0, 1); idle(3);
    drive(1, 1, 0, 0, 0, 10, 0, 1); idle(2);
    // R9 back-to-back promoting hits
    drive(1, 1, 0, 0, 1, 11, 0, 1); drive(1, 1, 0, 0, 1, 12, 0, 1);
    drive(1, 1, 0, 0, 1, 12, 0, 1); idle(1);
    // R6 miss while promoting ends the run (R8)
    drive(0, 0, 0, 0, 0, 0, 1, 1); idle(2);
    // R5 threshold outside profiling
    drive(1, 1, 1, 0, 0, 13, 0, 1);
    drive(1, 1, 0, 0, 1, 14, 0, 0); idle(2);
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 55, $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
            $urandom_range(0, 63), $urandom_range(0, 9) == 0,
            $urandom_range(0, 4) != 0);
    end
    idle(3);
    summary();
  end
endmodule